// File: doc/BRIEF.md
# Sensor-Triggered Intersection Signal Controller

This block sequences the six lamps of a T junction where a main road meets a side street. The main road shows green until a side-street request sensor is seen high at a clock edge. The controller then enters a short hold phase. During the hold the main road stays green. If the request disappears during the hold, the controller gives up and returns to main green, so that a vehicle turning right on red does not force a full cycle.

If the request persists, the controller runs a fixed cycle: main amber, then main red with side green, then side amber, then back to main green. Four delay inputs set how long the hold and each of the three later phases last. One shared timer counts within a phase and restarts at zero on every phase change. The sensor is expected to be already synchronous to the clock.

Top module: `tsig_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in main green with the phase timer at zero. A side request seen right after reset therefore gets a hold phase of full length.
- R2: While in main green, a low request sensor keeps the controller in main green on every edge.
- R3: A high request sensor at an edge in main green moves the controller to the hold phase. The hold phase drives the same lamps as main green.
- R4: In the hold phase, a low request sensor at an edge returns the controller to main green and clears the timer. A later request then gets a hold of full length again.
- R5: Phase order: hold, main amber, side green, side amber, then main green. The controller leaves the hold toward main amber only if the sensor is still high at the edge where the hold time ends.
- R6: The phase timer starts each timed phase at zero and adds one per clock until it equals that phase's delay input. With a delay value of N, the phase therefore lasts N+1 clock cycles. The delay inputs map to phases as follows: `dly_hold` to the hold, `dly_main_amb` to main amber, `dly_side_go` to side green, and `dly_side_amb` to side amber.
- R7: Lamp patterns, each written as the 6-bit vector {main green, main amber, main red, side green, side amber, side red}:
  - main green and hold: 100001
  - main amber: 010001
  - side green: 001100
  - side amber: 001010
  
  Exactly one lamp per road is lit at every cycle.
- R8: A delay of zero makes its phase last exactly one clock cycle. The largest delay value (all ones) gives 2^DLY_W cycles.
- R9: The request sensor has no effect in main amber, side green and side amber. Phase lengths and lamps there do not change with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_sense | input | 1 | Side-street request sensor, synchronous, active high |
| dly_hold | input | DLY_W | Hold phase length minus one, in cycles |
| dly_main_amb | input | DLY_W | Main amber length minus one |
| dly_side_go | input | DLY_W | Side green length minus one |
| dly_side_amb | input | DLY_W | Side amber length minus one |
| lamp_main_grn | output | 1 | Main road green |
| lamp_main_amb | output | 1 | Main road amber |
| lamp_main_red | output | 1 | Main road red |
| lamp_side_grn | output | 1 | Side street green |
| lamp_side_amb | output | 1 | Side street amber |
| lamp_side_red | output | 1 | Side street red |

## Verification
The sensor and the timer match are sampled at a rising edge, and the resulting lamp pattern appears one register later, in the cycle after that edge. Each lamp change is therefore due exactly one edge after the stimulus that causes it.

The bench drives the sensor at the falling edge and queues, for that same edge, the lamp pattern the requirements predict. A monitor then pops and compares that entry shortly after the following rising edge, so each expectation lines up with the one edge it describes. Phase lengths are checked as runs of N+1 identical entries, with the first differing entry expected on the edge where the timer reaches the delay.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

   localparam logic [2:0] PH_MAIN_GO  = 3'b000;
   localparam logic [2:0] PH_HOLD     = 3'b001;
   localparam logic [2:0] PH_MAIN_AMB = 3'b010;
   localparam logic [2:0] PH_SIDE_GO  = 3'b011;
   localparam logic [2:0] PH_SIDE_AMB = 3'b100;

   localparam int NUM_DLY = 4;

   typedef struct packed {
      logic m_g;
      logic m_a;
      logic m_r;
      logic s_g;
      logic s_a;
      logic s_r;
   } lamp_t;

   localparam lamp_t LAMP_MAIN_GO  = '{m_g:1'b1, m_a:1'b0, m_r:1'b0, s_g:1'b0, s_a:1'b0, s_r:1'b1};
   localparam lamp_t LAMP_MAIN_AMB = '{m_g:1'b0, m_a:1'b1, m_r:1'b0, s_g:1'b0, s_a:1'b0, s_r:1'b1};
   localparam lamp_t LAMP_SIDE_GO  = '{m_g:1'b0, m_a:1'b0, m_r:1'b1, s_g:1'b1, s_a:1'b0, s_r:1'b0};
   localparam lamp_t LAMP_SIDE_AMB = '{m_g:1'b0, m_a:1'b0, m_r:1'b1, s_g:1'b0, s_a:1'b1, s_r:1'b0};

   function automatic lamp_t lamp_of(input logic [2:0] ph);
      lamp_t l;
      case (ph)
         PH_MAIN_AMB: l = LAMP_MAIN_AMB;
         PH_SIDE_GO:  l = LAMP_SIDE_GO;
         PH_SIDE_AMB: l = LAMP_SIDE_AMB;
         default:     l = LAMP_MAIN_GO;
      endcase
      return l;
   endfunction

   function automatic logic [2:0] phase_after(input logic [2:0] ph);
      logic [2:0] n;
      case (ph)
         PH_HOLD:     n = PH_MAIN_AMB;
         PH_MAIN_AMB: n = PH_SIDE_GO;
         PH_SIDE_GO:  n = PH_SIDE_AMB;
         default:     n = PH_MAIN_GO;
      endcase
      return n;
   endfunction

   function automatic logic is_timed(input logic [2:0] ph);
      return (ph == PH_HOLD) || (ph == PH_MAIN_AMB) ||
             (ph == PH_SIDE_GO) || (ph == PH_SIDE_AMB);
   endfunction

endpackage

// File: rtl/tsig_delay_sel.sv
module tsig_delay_sel
   import tsig_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic [2:0]                       phase,
   input  logic [NUM_DLY-1:0][DLY_W-1:0]    dly_vec,
   output logic [DLY_W-1:0]                 limit
);

   localparam int IDX_W = $clog2(NUM_DLY);

   logic [IDX_W-1:0] idx;
   logic             valid;

   always_comb begin
      valid = is_timed(phase);
      idx   = IDX_W'(phase - 3'd1);
   end

   always_comb begin
      limit = '0;
      if (valid) begin
         limit = dly_vec[idx];
      end
   end

endmodule

// File: rtl/tsig_phase_timer.sv
module tsig_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (inc && !at_limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      count    = cnt_q;
      at_limit = (cnt_q == limit);
   end

endmodule

// File: rtl/tsig_seq_fsm.sv
module tsig_seq_fsm
   import tsig_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req,
   input  logic       at_limit,
   output logic [2:0] phase_q,
   output logic [2:0] phase_d,
   output logic       tmr_clr,
   output logic       tmr_inc
);

   logic [2:0] cur_q;

   always_comb begin
      phase_d = cur_q;
      tmr_clr = 1'b0;
      tmr_inc = 1'b0;
      case (cur_q)
         PH_MAIN_GO: begin
            tmr_clr = 1'b1;
            if (req) begin
               phase_d = PH_HOLD;
            end
         end
         PH_HOLD: begin
            if (!req) begin
               phase_d = PH_MAIN_GO;
               tmr_clr = 1'b1;
            end else if (at_limit) begin
               phase_d = phase_after(cur_q);
               tmr_clr = 1'b1;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         PH_MAIN_AMB, PH_SIDE_GO, PH_SIDE_AMB: begin
            if (at_limit) begin
               phase_d = phase_after(cur_q);
               tmr_clr = 1'b1;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         default: begin
            phase_d = PH_MAIN_GO;
            tmr_clr = 1'b1;
         end
      endcase
      if (rst) begin
         phase_d = PH_MAIN_GO;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= PH_MAIN_GO;
      end else begin
         cur_q <= phase_d;
      end
   end

   assign phase_q = cur_q;

endmodule

// File: rtl/tsig_ctrl.sv
module tsig_ctrl
   import tsig_pkg::*;
#(
   parameter int DLY_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_sense,
   input  logic [DLY_W-1:0] dly_hold,
   input  logic [DLY_W-1:0] dly_main_amb,
   input  logic [DLY_W-1:0] dly_side_go,
   input  logic [DLY_W-1:0] dly_side_amb,
   output logic             lamp_main_grn,
   output logic             lamp_main_amb,
   output logic             lamp_main_red,
   output logic             lamp_side_grn,
   output logic             lamp_side_amb,
   output logic             lamp_side_red
);

   if (DLY_W < 1 || DLY_W > 32) begin : g_bad_width
      $error("tsig_ctrl: DLY_W must lie in 1..32");
   end

   logic [NUM_DLY-1:0][DLY_W-1:0] dly_vec;
   logic [DLY_W-1:0]              cur_limit;
   logic [DLY_W-1:0]              tmr_q;
   logic                          at_limit;
   logic                          tmr_clr;
   logic                          tmr_inc;
   logic [2:0]                    phase_q;
   logic [2:0]                    phase_d;
   lamp_t                         lamps;

   assign dly_vec = {dly_side_amb, dly_side_go, dly_main_amb, dly_hold};

   tsig_delay_sel #(.DLY_W(DLY_W)) u_sel (
      .phase   (phase_q),
      .dly_vec (dly_vec),
      .limit   (cur_limit)
   );

   tsig_phase_timer #(.CNT_W(DLY_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .clr      (tmr_clr),
      .inc      (tmr_inc),
      .limit    (cur_limit),
      .count    (tmr_q),
      .at_limit (at_limit)
   );

   tsig_seq_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .req      (req_sense),
      .at_limit (at_limit),
      .phase_q  (phase_q),
      .phase_d  (phase_d),
      .tmr_clr  (tmr_clr),
      .tmr_inc  (tmr_inc)
   );

   if (OUT_REG) begin : g_lamp_flop
      lamp_t lamp_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            lamp_q <= LAMP_MAIN_GO;
         end else begin
            lamp_q <= lamp_of(phase_d);
         end
      end
      assign lamps = lamp_q;
   end else begin : g_lamp_comb
      logic [2:0] unused_d;
      assign unused_d = phase_d;
      assign lamps    = lamp_of(phase_q);
   end

   assign lamp_main_grn = lamps.m_g;
   assign lamp_main_amb = lamps.m_a;
   assign lamp_main_red = lamps.m_r;
   assign lamp_side_grn = lamps.s_g;
   assign lamp_side_amb = lamps.s_a;
   assign lamp_side_red = lamps.s_r;

endmodule

// File: rtl/tsig_ctrl_chk.sv
module tsig_ctrl_chk
   import tsig_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             req_sense,
   input logic [2:0]       phase_q,
   input logic [DLY_W-1:0] tmr_q,
   input logic [DLY_W-1:0] dly_hold,
   input logic [DLY_W-1:0] dly_main_amb,
   input logic [DLY_W-1:0] dly_side_go,
   input logic [DLY_W-1:0] dly_side_amb,
   input logic             lamp_main_grn,
   input logic             lamp_main_amb,
   input logic             lamp_main_red,
   input logic             lamp_side_grn,
   input logic             lamp_side_amb,
   input logic             lamp_side_red
);

   logic [DLY_W-1:0] lim;
   logic             timed;
   logic             abort;

   always_comb begin
      case (phase_q)
         PH_HOLD:     lim = dly_hold;
         PH_MAIN_AMB: lim = dly_main_amb;
         PH_SIDE_GO:  lim = dly_side_go;
         default:     lim = dly_side_amb;
      endcase
      timed = is_timed(phase_q);
      abort = (phase_q == PH_HOLD) && !req_sense;
   end

   // R1: no count accumulates in main green
   a_r1_green_timer_zero: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_MAIN_GO) |-> (tmr_q == '0));

   a_r2_stay_green: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_MAIN_GO && !req_sense) |=> (phase_q == PH_MAIN_GO));

   a_r3_enter_hold: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_MAIN_GO && req_sense) |=> (phase_q == PH_HOLD));

   a_r4_hold_abort: assert property (@(posedge clk) disable iff (rst)
      abort |=> (phase_q == PH_MAIN_GO && tmr_q == '0));

   a_r6_timer_step: assert property (@(posedge clk) disable iff (rst)
      (timed && !abort && tmr_q != lim) |=>
         (tmr_q == $past(tmr_q) + 1'b1 && phase_q == $past(phase_q)));

   // R5 order and R6 restart at zero
   a_r5_phase_exit: assert property (@(posedge clk) disable iff (rst)
      (timed && !abort && tmr_q == lim) |=>
         (phase_q == phase_after($past(phase_q)) && tmr_q == '0));

   a_r7_one_lamp_per_road: assert property (@(posedge clk) disable iff (rst)
      ($countones({lamp_main_grn, lamp_main_amb, lamp_main_red}) == 1) &&
      ($countones({lamp_side_grn, lamp_side_amb, lamp_side_red}) == 1));

   a_r7_no_double_green: assert property (@(posedge clk) disable iff (rst)
      !(lamp_main_grn && lamp_side_grn));

endmodule

bind tsig_ctrl tsig_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .req_sense     (req_sense),
   .phase_q       (phase_q),
   .tmr_q         (tmr_q),
   .dly_hold      (dly_hold),
   .dly_main_amb  (dly_main_amb),
   .dly_side_go   (dly_side_go),
   .dly_side_amb  (dly_side_amb),
   .lamp_main_grn (lamp_main_grn),
   .lamp_main_amb (lamp_main_amb),
   .lamp_main_red (lamp_main_red),
   .lamp_side_grn (lamp_side_grn),
   .lamp_side_amb (lamp_side_amb),
   .lamp_side_red (lamp_side_red)
);

// File: tb/tsig_ctrl_bench.sv
module tsig_ctrl_bench;

   localparam int W = 8;
   localparam logic [5:0] L_G = 6'b100001;
   localparam logic [5:0] L_Y = 6'b010001;
   localparam logic [5:0] L_H = 6'b001100;
   localparam logic [5:0] L_S = 6'b001010;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst = 1'b1;
   logic         req = 1'b0;
   logic [W-1:0] d_hold = '0, d_amb = '0, d_sgo = '0, d_samb = '0;
   logic         mg, ma, mr, sg, sa, sr;

   typedef struct {
      logic [5:0] lamps;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   tests = 0;
   int   fails = 0;
   bit   done  = 1'b0;

   tsig_ctrl #(.DLY_W(W)) u_tsig_ctrl (
      .clk           (clk),
      .rst           (rst),
      .req_sense     (req),
      .dly_hold      (d_hold),
      .dly_main_amb  (d_amb),
      .dly_side_go   (d_sgo),
      .dly_side_amb  (d_samb),
      .lamp_main_grn (mg),
      .lamp_main_amb (ma),
      .lamp_main_red (mr),
      .lamp_side_grn (sg),
      .lamp_side_amb (sa),
      .lamp_side_red (sr)
   );

   wire [5:0] obs = {mg, ma, mr, sg, sa, sr};

   // monitor: one queued expectation per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            tests++;
            if (obs !== it.lamps) begin
               fails++;
               $display("FAIL %s: lamps=%b expected %b at %0t", it.tag, obs, it.lamps, $time);
            end
         end
      end
   end

   task automatic step(input logic s, input logic [5:0] e, input string tag);
      @(negedge clk);
      rst = 1'b0;
      req = s;
      q.push_back('{lamps: e, tag: tag});
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1;
      req = 1'b1;
      q.push_back('{lamps: L_G, tag: tag});
   endtask

   // full request cycle; noise drives the sensor high where it must be ignored
   task automatic sweep(input int p, input int a, input int h, input int s,
                        input logic noise, input string tag);
      d_hold = W'(p); d_amb = W'(a); d_sgo = W'(h); d_samb = W'(s);
      step(1'b1, L_G, {"R3 enter hold ", tag});
      for (int i = 0; i < p; i++) step(1'b1, L_G, {"R6 hold length ", tag});
      step(1'b1, L_Y, {"R5 hold to main amber ", tag});
      for (int i = 0; i < a; i++) step(noise, L_Y, {"R9 R6 main amber ", tag});
      for (int i = 0; i <= h; i++) step(noise, L_H, {"R7 R6 side green ", tag});
      for (int i = 0; i <= s; i++) step(noise, L_S, {"R7 R6 side amber ", tag});
      step(1'b0, L_G, {"R5 back to main green ", tag});
      step(1'b0, L_G, {"R2 idle ", tag});
   endtask

   initial begin
      do_reset("R1 reset state");
      for (int i = 0; i < 4; i++) step(1'b0, L_G, "R2 stays green");
      sweep(3, 1, 2, 0, 1'b0, "basic");
      sweep(0, 0, 0, 0, 1'b1, "R8 zero delays");
      sweep(2, 3, 1, 2, 1'b1, "R9 sensor noise");
      // R4: abort in hold, then a full-length hold
      d_hold = W'(4);
      step(1'b1, L_G, "R4 hold t0");
      step(1'b1, L_G, "R4 hold t1");
      step(1'b0, L_G, "R4 abort to green");
      step(1'b0, L_G, "R4 green after abort");
      sweep(4, 0, 0, 0, 1'b0, "R4 full hold after abort");
      // R1: reset in the middle of a cycle
      d_hold = W'(1); d_amb = W'(5);
      step(1'b1, L_G, "R1 pre hold");
      step(1'b1, L_G, "R1 pre hold t1");
      step(1'b1, L_Y, "R1 pre amber");
      step(1'b1, L_Y, "R1 pre amber t1");
      do_reset("R1 mid-cycle reset");
      step(1'b0, L_G, "R1 green after reset");
      sweep(2, 1, 1, 1, 1'b0, "R1 after reset");
      sweep(255, 255, 255, 255, 1'b0, "R8 max delays");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not end, actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule